// File: doc/BRIEF.md
# Anytime Subword Multiply-Accumulate Unit

This block computes a sum of products over a small set of operand pairs (for two pairs, a0·x0 + a1·x1). The first operand of every pair is cut into subwords, and the block works through them by weight. It adds the top subword of every pair, shifted into place, before it adds any lower subword. Once that top pass is finished, the accumulator holds a coarse but usable result, and a one-cycle skim pulse marks that point. A consumer that is short of energy or time can take the value there and abandon the rest. If the block keeps running, the lower passes bring the accumulator to the exact sum and raise a done flag.

A precision input chooses the subword size. With 8-bit subwords, each 16-bit operand takes two passes. With 4-bit subwords it takes four passes, from the top nibble down. A subword equal to zero is skipped and uses no cycle. Each subword product goes through a small direct-mapped table. When the same subword meets the same second operand again, the stored product is used and the multiplier is not needed. Operands are written one pair at a time while the unit is idle. The accumulator output can be read in every cycle.

Top module: `subword_skim_mac`

## Requirements
- R1: While reset is held and in the first cycle after the synchronized release, acc_out is 0 and skim_valid, done and memo_hit are 0.
- R2: In an idle cycle, ld_en writes ld_a and ld_x into the pair selected by ld_sel. ld_en is ignored while a run is in progress, and the stored operands then stay unchanged.
- R3: start in an idle cycle clears the accumulator and captures prec_4b for the whole run. start, and any change of prec_4b, are ignored while a run is in progress.
- R4: With prec_4b = 0, the subwords are a[15:8] (weight 2^8) and a[7:0] (weight 1). In the cycle skim_valid is high, acc_out equals the sum over pairs of a[15:8]·x·256.
- R5: With prec_4b = 1, the subwords are the nibbles a[15:12], a[11:8], a[7:4] and a[3:0], taken in that order. In the cycle skim_valid is high, acc_out equals the sum over pairs of a[15:12]·x·4096.
- R6: When done rises, acc_out equals the exact sum of a·x over all pairs. done and acc_out then hold until the next accepted start.
- R7: skim_valid is high for exactly one cycle per run. It is never high later than the cycle in which done first appears.
- R8: Zero subwords take no cycle. Count the cycles from the start edge to the edge that raises done, with nh the number of nonzero top subwords and nl the number of nonzero lower subwords. The count is nh+nl when nh > 0, and nl+1 when nh = 0.
- R9: Products come from a 16-entry direct-mapped table indexed by {subword[1:0], x[1:0]}. An entry hits when its stored subword and stored x both match. A hit raises memo_hit in the cycle its product shows in acc_out. Reset clears every entry, and a miss fills the entry.
- R10: During a run, acc_out never decreases from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ld_en | input | 1 | Write one operand pair |
| ld_sel | input | 1 | Pair index to write |
| ld_a | input | 16 | Operand that gets split into subwords |
| ld_x | input | 16 | Full-width second operand |
| prec_4b | input | 1 | 1: 4-bit subwords, 0: 8-bit subwords |
| start | input | 1 | Begin a run |
| acc_out | output | 33 | Accumulator, readable in every cycle |
| skim_valid | output | 1 | One-cycle pulse marking the approximate result |
| done | output | 1 | Exact result present, held until the next start |
| memo_hit | output | 1 | The product added in this cycle came from the table |

## Verification
The bench uses the default build: two operand pairs, 16-bit words and a 16-entry table. With these values a run has at most eight subword items. A sweep can therefore run more than a hundred operand sets in both precision modes, and for each one predict the skim value, the exact value and the cycle count with plain arithmetic. The operand sets are built so that top-only, bottom-only, fully zero and fully dense subword patterns all occur. The small table allows a hand-picked vector that fills four distinct entries, so the miss-then-hit behaviour and the clearing on reset are each shown exactly.

// File: rtl/amac_pkg.sv
package amac_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } amac_state_e;

  localparam int unsigned PASSES_MAX = 4;
endpackage

// File: rtl/amac_opbank.sv
module amac_opbank #(
  parameter int unsigned N_TERMS = 2,
  parameter int unsigned OPW     = 16,
  localparam int unsigned SELW   = (N_TERMS > 1) ? $clog2(N_TERMS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [SELW-1:0]                wr_sel,
  input  logic [OPW-1:0]                 wr_a,
  input  logic [OPW-1:0]                 wr_x,
  output logic [N_TERMS-1:0][OPW-1:0]    a_o,
  output logic [N_TERMS-1:0][OPW-1:0]    x_o
);
  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    logic           we;
    logic [OPW-1:0] a_q, x_q;

    always_comb we = wr_en && (wr_sel == SELW'(t));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= '0;
        x_q <= '0;
      end else if (we) begin
        a_q <= wr_a;
        x_q <= wr_x;
      end
    end

    assign a_o[t] = a_q;
    assign x_o[t] = x_q;
  end
endmodule

// File: rtl/amac_seq.sv
module amac_seq
  import amac_pkg::*;
#(
  parameter int unsigned N_TERMS = 2,
  parameter int unsigned OPW     = 16,
  localparam int unsigned HW     = OPW / 2,
  localparam int unsigned QW     = OPW / 4,
  localparam int unsigned SHW    = $clog2(OPW),
  localparam int unsigned NITEM  = PASSES_MAX * N_TERMS,
  localparam int unsigned IW     = $clog2(NITEM),
  localparam int unsigned KW     = $clog2(NITEM + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_go,
  input  logic                        mode4_in,
  input  logic [N_TERMS-1:0][OPW-1:0] a_i,
  input  logic [N_TERMS-1:0][OPW-1:0] x_i,
  output logic                        issue,
  output logic [HW-1:0]               iss_sub,
  output logic [OPW-1:0]              iss_x,
  output logic [SHW-1:0]              iss_shift,
  output logic                        busy,
  output logic                        skim_o,
  output logic                        done_o
);
  amac_state_e state_q, state_n;
  logic [KW-1:0] k_q, k_n;
  logic          skim_given_q, skim_given_n;
  logic          mode4_q, mode4_n;
  logic          skim_q, skim_n;
  logic          done_q, done_n;

  logic [NITEM-1:0][HW-1:0]  sub_arr;
  logic [NITEM-1:0][SHW-1:0] shf_arr;
  logic [NITEM-1:0][OPW-1:0] x_arr;
  logic [NITEM-1:0]          nz, elig, is_hi;

  for (genvar i = 0; i < NITEM; i++) begin : g_item
    localparam int unsigned P   = i / N_TERMS;
    localparam int unsigned T   = i % N_TERMS;
    localparam int unsigned SH4 = (PASSES_MAX - 1 - P) * QW;
    logic [HW-1:0]  sub8;
    logic [SHW-1:0] shf8;
    if (P == 0) begin : g_p0
      assign sub8 = a_i[T][HW +: HW];
      assign shf8 = SHW'(HW);
    end else if (P == 1) begin : g_p1
      assign sub8 = a_i[T][0 +: HW];
      assign shf8 = '0;
    end else begin : g_pn
      assign sub8 = '0;
      assign shf8 = '0;
    end
    always_comb begin
      if (mode4_q) begin
        sub_arr[i] = {{(HW-QW){1'b0}}, a_i[T][SH4 +: QW]};
        shf_arr[i] = SHW'(SH4);
      end else begin
        sub_arr[i] = sub8;
        shf_arr[i] = shf8;
      end
      x_arr[i] = x_i[T];
      nz[i]    = (sub_arr[i] != '0);
      is_hi[i] = (P == 0);
      elig[i]  = nz[i] && (KW'(i) >= k_q) && (skim_given_q || is_hi[i]);
    end
  end

  logic          found, more, lo_any;
  logic [IW-1:0] sel;

  always_comb begin
    found  = 1'b0;
    more   = 1'b0;
    sel    = '0;
    lo_any = |(nz & ~is_hi);
    for (int j = 0; j < NITEM; j++) begin
      if (elig[j]) begin
        if (!found) begin
          found = 1'b1;
          sel   = IW'(j);
        end else begin
          more = 1'b1;
        end
      end
    end
  end

  always_comb begin
    state_n      = state_q;
    k_n          = k_q;
    skim_given_n = skim_given_q;
    mode4_n      = mode4_q;
    skim_n       = 1'b0;
    done_n       = done_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_go) begin
          state_n      = ST_RUN;
          k_n          = '0;
          skim_given_n = 1'b0;
          mode4_n      = mode4_in;
          done_n       = 1'b0;
        end
      end
      ST_RUN: begin
        if (more) begin
          k_n = KW'(sel) + KW'(1);
        end else if (!skim_given_q) begin
          skim_n       = 1'b1;
          skim_given_n = 1'b1;
          k_n          = KW'(N_TERMS);
          if (!lo_any) begin
            done_n  = 1'b1;
            state_n = ST_IDLE;
          end
        end else begin
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      k_q          <= '0;
      skim_given_q <= 1'b0;
      mode4_q      <= 1'b0;
      skim_q       <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      state_q      <= state_n;
      k_q          <= k_n;
      skim_given_q <= skim_given_n;
      mode4_q      <= mode4_n;
      skim_q       <= skim_n;
      done_q       <= done_n;
    end
  end

  assign busy      = (state_q == ST_RUN);
  assign issue     = busy && found;
  assign iss_sub   = sub_arr[sel];
  assign iss_shift = shf_arr[sel];
  assign iss_x     = x_arr[sel];
  assign skim_o    = skim_q;
  assign done_o    = done_q;

  // R8: a zero subword never reaches the multiplier path
  p_skip_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (iss_sub != '0));

  // R4/R5: after the skim point only lower-weight subwords are issued
  p_hi_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && skim_given_q) |->
      (iss_shift < (mode4_q ? SHW'((PASSES_MAX - 1) * QW) : SHW'(HW))));
endmodule

// File: rtl/amac_memo.sv
module amac_memo #(
  parameter int unsigned OPW       = 16,
  parameter int unsigned LUT_DEPTH = 16,
  localparam int unsigned HW       = OPW / 2,
  localparam int unsigned PW       = HW + OPW,
  localparam int unsigned IDXW     = $clog2(LUT_DEPTH),
  localparam int unsigned IDX_S    = IDXW / 2,
  localparam int unsigned IDX_X    = IDXW - IDX_S
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic [HW-1:0]  sub,
  input  logic [OPW-1:0] xop,
  output logic [PW-1:0]  prod,
  output logic           hit
);
  logic [LUT_DEPTH-1:0] vld_q;
  logic [HW-1:0]        tag_s_q [LUT_DEPTH];
  logic [OPW-1:0]       tag_x_q [LUT_DEPTH];
  logic [PW-1:0]        data_q  [LUT_DEPTH];

  logic [IDXW-1:0] idx;
  logic [PW-1:0]   mul;
  logic            fill;

  always_comb begin
    idx  = {sub[IDX_S-1:0], xop[IDX_X-1:0]};
    mul  = PW'(sub) * PW'(xop);
    hit  = vld_q[idx] && (tag_s_q[idx] == sub) && (tag_x_q[idx] == xop);
    prod = hit ? data_q[idx] : mul;
    fill = req && !hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (fill) begin
      vld_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag_s_q[idx] <= sub;
      tag_x_q[idx] <= xop;
      data_q[idx]  <= mul;
    end
  end

  // R9: a stored product always equals the product of its tags
  p_memo_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && hit) |-> (data_q[idx] == mul));
endmodule

// File: rtl/subword_skim_mac.sv
module subword_skim_mac #(
  parameter int unsigned N_TERMS   = 2,
  parameter int unsigned OPW       = 16,
  parameter int unsigned LUT_DEPTH = 16,
  localparam int unsigned SELW     = (N_TERMS > 1) ? $clog2(N_TERMS) : 1,
  localparam int unsigned HW       = OPW / 2,
  localparam int unsigned PW       = HW + OPW,
  localparam int unsigned SHW      = $clog2(OPW),
  localparam int unsigned ACCW     = 2 * OPW + $clog2(N_TERMS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic [SELW-1:0] ld_sel,
  input  logic [OPW-1:0]  ld_a,
  input  logic [OPW-1:0]  ld_x,
  input  logic            prec_4b,
  input  logic            start,
  output logic [ACCW-1:0] acc_out,
  output logic            skim_valid,
  output logic            done,
  output logic            memo_hit
);
  logic rs1_q, rs2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  logic srst_n;
  assign srst_n = rs2_q;

  logic busy, start_go, wr_en;
  logic [N_TERMS-1:0][OPW-1:0] a_w, x_w;
  logic            issue, hit;
  logic [HW-1:0]   iss_sub;
  logic [OPW-1:0]  iss_x;
  logic [SHW-1:0]  iss_shift;
  logic [PW-1:0]   prod;

  assign start_go = start && !busy;
  assign wr_en    = ld_en && !busy;

  amac_opbank #(.N_TERMS(N_TERMS), .OPW(OPW)) u_bank (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .wr_sel(ld_sel),
    .wr_a(ld_a), .wr_x(ld_x), .a_o(a_w), .x_o(x_w)
  );

  amac_seq #(.N_TERMS(N_TERMS), .OPW(OPW)) u_seq (
    .clk(clk), .rst_n(srst_n), .start_go(start_go), .mode4_in(prec_4b),
    .a_i(a_w), .x_i(x_w), .issue(issue), .iss_sub(iss_sub), .iss_x(iss_x),
    .iss_shift(iss_shift), .busy(busy), .skim_o(skim_valid), .done_o(done)
  );

  amac_memo #(.OPW(OPW), .LUT_DEPTH(LUT_DEPTH)) u_memo (
    .clk(clk), .rst_n(srst_n), .req(issue), .sub(iss_sub), .xop(iss_x),
    .prod(prod), .hit(hit)
  );

  logic [ACCW-1:0] acc_q, acc_n;
  logic            hit_q, hit_n;

  always_comb begin
    acc_n = acc_q;
    hit_n = 1'b0;
    if (start_go) begin
      acc_n = '0;
    end else if (issue) begin
      acc_n = acc_q + (ACCW'(prod) << iss_shift);
      hit_n = hit;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      acc_q <= '0;
      hit_q <= 1'b0;
    end else begin
      acc_q <= acc_n;
      hit_q <= hit_n;
    end
  end

  assign acc_out  = acc_q;
  assign memo_hit = hit_q;

  // R10: accumulator grows monotonically inside a run
  p_acc_monotone_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && $past(busy)) |-> (acc_q >= $past(acc_q)));

  // R7: the skim marker is a single-cycle pulse
  p_skim_pulse_r7: assert property (@(posedge clk) disable iff (!srst_n)
    skim_valid |=> !skim_valid);

  // R6: done is held while no new start is accepted
  p_done_hold_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (done && !start) |=> (done && $stable(acc_q)));
endmodule

// File: tb/subword_skim_mac_bench.sv
module subword_skim_mac_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [0:0]  ld_sel = '0;
  logic [15:0] ld_a = '0, ld_x = '0;
  logic        prec_4b = 1'b0;
  logic        start = 1'b0;
  logic [32:0] acc_out;
  logic        skim_valid, done, memo_hit;

  always #4 clk = ~clk;

  subword_skim_mac u_subword_skim_mac (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_a(ld_a),
    .ld_x(ld_x), .prec_4b(prec_4b), .start(start), .acc_out(acc_out),
    .skim_valid(skim_valid), .done(done), .memo_hit(memo_hit)
  );

  int n_chk = 0, n_bad = 0;
  bit reported = 0;
  int cyc, skim_cnt, hits;
  longint skim_acc, fin_acc;
  logic [15:0] va [2], vx [2];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] a0, x0, a1, x1);
    va[0] = a0; vx[0] = x0; va[1] = a1; vx[1] = x1;
    for (int t = 0; t < 2; t++) begin
      ld_en = 1'b1; ld_sel = 1'(t); ld_a = va[t]; ld_x = vx[t];
      @(negedge clk);
    end
    ld_en = 1'b0;
  endtask

  task automatic run(input bit m4, input bit inject);
    prec_4b = m4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; skim_cnt = 0; hits = 0; skim_acc = -1;
    if (inject) begin
      ld_en = 1'b1; ld_sel = 1'b0; ld_a = 16'hFFFF; ld_x = 16'hFFFF;
      start = 1'b1; prec_4b = ~m4;
    end
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        ld_en = 1'b0; start = 1'b0; prec_4b = m4;
      end
      if (skim_valid) begin
        skim_cnt++;
        skim_acc = longint'(acc_out);
      end
      if (memo_hit) hits++;
      if (done) break;
      if (cyc > 100) begin
        chk(0, "R6 run did not finish", cyc, 0);
        break;
      end
    end
    fin_acc = longint'(acc_out);
  endtask

  task automatic check_run(input bit m4, input string tag);
    longint e_hi = 0, e_fin = 0;
    int nh = 0, nl = 0, ecyc;
    for (int t = 0; t < 2; t++) begin
      e_fin += longint'(va[t]) * longint'(vx[t]);
      if (m4) begin
        e_hi += (longint'(va[t] >> 12) * longint'(vx[t])) << 12;
        for (int q = 0; q < 4; q++)
          if (((va[t] >> (12 - 4*q)) & 16'hF) != 0) begin
            if (q == 0) nh++; else nl++;
          end
      end else begin
        e_hi += (longint'(va[t] >> 8) * longint'(vx[t])) << 8;
        if ((va[t] >> 8) != 0) nh++;
        if ((va[t] & 16'hFF) != 0) nl++;
      end
    end
    ecyc = (nh == 0) ? nl + 1 : nh + nl;
    chk(skim_cnt == 1, {tag, " R7 skim count"}, skim_cnt, 1);
    chk(skim_acc == e_hi, m4 ? {tag, " R5 skim value"} : {tag, " R4 skim value"}, skim_acc, e_hi);
    chk(fin_acc == e_fin, {tag, " R6 final value"}, fin_acc, e_fin);
    chk(cyc == ecyc, {tag, " R8 cycle count"}, cyc, ecyc);
    @(negedge clk);
    chk(done && longint'(acc_out) == e_fin, {tag, " R6 held result"}, longint'(acc_out), e_fin);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    rst_n = 1'b0;
    @(negedge clk);
    chk(acc_out == 0 && !done && !skim_valid && !memo_hit, "R1 during reset", longint'(acc_out), 0);
    do_reset();
    chk(acc_out == 0 && !done && !skim_valid && !memo_hit, "R1 after release", longint'(acc_out), 0);

    // R9: four distinct table slots, cold then warm
    load(16'h0102, 16'h0004, 16'h0102, 16'h0005);
    run(1'b0, 1'b0);
    check_run(1'b0, "memo cold");
    chk(hits == 0, "R9 cold table hits", hits, 0);
    run(1'b0, 1'b0);
    check_run(1'b0, "memo warm");
    chk(hits == 4, "R9 warm table hits", hits, 4);

    // R2/R3: loads, start and mode changes during a run are ignored
    load(16'h9A7C, 16'h3141, 16'hB5D3, 16'h2718);
    run(1'b1, 1'b1);
    check_run(1'b1, "R3 busy start");
    run(1'b1, 1'b0);
    check_run(1'b1, "R2 operands kept");

    // sweep over both modes with forced zero subword patterns
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 64; i++) begin
        logic [15:0] a0, a1, x0, x1;
        a0 = 16'(i * 16'h9E37 + 16'h1357);
        a1 = 16'(i * 16'h6B1D + 16'h8421);
        x0 = 16'(i * 16'h03C5) ^ 16'hA5A5;
        x1 = 16'hFFFF - 16'(i * 7);
        case (i % 6)
          1: a0 &= 16'h00FF;
          2: a1 &= 16'hFF00;
          3: begin a0 &= 16'hF0F0; a1 &= 16'h0F0F; end
          4: begin a0 = 16'h0000; a1 &= 16'h0FFF; end
          5: if (i % 12 == 5) begin a0 = 16'h0000; a1 = 16'h0000; end
          default: ;
        endcase
        load(a0, x0, a1, x1);
        run(1'(m), 1'b0);
        check_run(1'(m), m ? "sweep4" : "sweep8");
      end
    end

    // R9: reset empties the table
    do_reset();
    load(16'h0102, 16'h0004, 16'h0102, 16'h0005);
    run(1'b0, 1'b0);
    check_run(1'b0, "memo after reset");
    chk(hits == 0, "R9 table cleared by reset", hits, 0);

    report();
  end
endmodule